// File: doc/BRIEF.md
# Serial Nibble Write Port

This block is the input side of a sequential-access video memory. A 4-bit data bus is sampled whenever an external shift clock rises, and each sample enters a 16-word shift register. When an external write-transfer strobe falls, the whole register is copied into a holding latch. The memory write cycle then reads its data from that latch. Because the register keeps shifting after the copy, the writer can stream data without a gap, provided it issues one transfer for every 16 words.

The shift clock, the strobe and the data bus are all asynchronous to the system clock. Each passes through a synchronizer of the same depth, so the data stays aligned with the clock edge that captures it. Edges are detected in the system clock domain. If the writer sends more than 16 words between two transfers, the oldest words drop out of the register. A status flag reports that this has happened. The flag stays set until the next transfer.

Top module: `serial_nibble_wport`

## Requirements
- R1: After reset the latch output is all zeros and the overflow flag is 0.
- R2: Each rising edge of `shift_clk_i` shifts exactly one 4-bit word from `data_i` into the register. Falling edges of `shift_clk_i` shift nothing.
- R3: A falling edge of `wr_xfer_n_i` copies the register into `latch_o`. Word 0 (bits 3:0) is the earliest of the 16 retained words, and word 15 (bits 63:60) is the most recent. A rising edge of `wr_xfer_n_i` leaves `latch_o` unchanged.
- R4: When more than 16 words arrive before a transfer, the latch receives only the last 16 of them, in arrival order.
- R5: `overflow_o` goes to 1 when the 17th word arrives after the previous transfer (or after reset). It returns to 0 at the next transfer.
- R6: Between transfers `latch_o` holds its value while shifting continues. Words shifted right after a transfer are kept for the following transfer, so none is lost.
- R7: A shift edge and a transfer edge that reach the same system cycle are handled shift first. The new word becomes word 15 of the latch, and it counts toward the batch just transferred, not toward the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples all external signals |
| rst_n | input | 1 | Active-low asynchronous reset |
| shift_clk_i | input | 1 | Asynchronous shift clock; data is taken on its rising edge |
| data_i | input | 4 | Serial nibble data bus |
| wr_xfer_n_i | input | 1 | Asynchronous write-transfer strobe; acts on its falling edge |
| latch_o | output | 64 | Holding latch, 16 words of 4 bits, word 0 in the low bits |
| overflow_o | output | 1 | Set when more than 16 words arrived since the last transfer |

## Verification
A shift edge and a transfer edge can be detected in the same system cycle. In that case the shift must complete first, so that the new word goes into the copy. The bench provokes this by raising the shift clock and lowering the strobe at the same instant. Both pass through synchronizers of equal depth, so the two edges are detected in the same cycle. The bench then checks two things: the new word must appear as word 15 of the latch, and the 16 words that follow must not set the overflow flag, which shows the coincident word was charged to the earlier batch.

// File: rtl/snw_pkg.sv
package snw_pkg;
    localparam int unsigned WORD_W      = 4;
    localparam int unsigned DEPTH       = 16;
    localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/snw_sync_pipe.sv
module snw_sync_pipe #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] st;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d       = pipe_q;
        pipe_d.st[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d.st[i] = pipe_q.st[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q.st[STAGES-1];
endmodule

// File: rtl/snw_edge_det.sv
module snw_edge_det #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    typedef struct packed {
        logic [WIDTH-1:0] hist;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d      = det_q;
        det_d.hist = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign rise_o = level_i & ~det_q.hist;
    assign fall_o = ~level_i & det_q.hist;

    // R2: a single edge of the input yields a single-cycle pulse
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/snw_shift_reg.sv
module snw_shift_reg
    import snw_pkg::*;
#(
    parameter int unsigned W = WORD_W,
    parameter int unsigned N = DEPTH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic [W-1:0]   din,
    output logic [N*W-1:0] sr_o,
    output logic [N*W-1:0] sr_next_o
);
    typedef struct packed {
        logic [N-1:0][W-1:0] w;
    } sr_t;

    sr_t sr_d, sr_q;
    logic [N-1:0][W-1:0] shifted;

    for (genvar g = 0; g < N; g++) begin : g_word
        if (g == N - 1) begin : g_newest
            assign shifted[g] = din;
        end else begin : g_older
            assign shifted[g] = sr_q.w[g+1];
        end
    end

    always_comb begin
        sr_d = sr_q;
        if (shift_en) begin
            sr_d.w = shifted;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign sr_o      = sr_q;
    assign sr_next_o = sr_d;

    // R2: without a shift edge the register does not move
    p_shift_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sr_q));
    // R4: on a shift the oldest word leaves and the rest move down
    p_shift_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> sr_q.w[0] == $past(sr_q.w[1]));
endmodule

// File: rtl/snw_xfer_latch.sv
module snw_xfer_latch
    import snw_pkg::*;
#(
    parameter int unsigned W = WORD_W,
    parameter int unsigned N = DEPTH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           xfer_en,
    input  logic [N*W-1:0] sr_next_i,
    output logic [N*W-1:0] latch_o,
    output logic           overflow_o
);
    localparam int unsigned CNT_W = $clog2(N + 2);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(N);
    localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(N + 1);

    typedef struct packed {
        logic [N*W-1:0] latch;
        logic [CNT_W-1:0] cnt;
        logic ovf;
    } lat_t;

    lat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (xfer_en) begin
            // shift-first: the next register value already holds the new word
            st_d.latch = sr_next_i;
            st_d.cnt   = '0;
            st_d.ovf   = 1'b0;
        end else if (shift_en) begin
            if (st_q.cnt != CNT_SAT) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_q.cnt >= CNT_LIMIT) begin
                st_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch_o    = st_q.latch;
    assign overflow_o = st_q.ovf;

    // R6: the latch holds between transfers
    p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_en |=> $stable(st_q.latch));
    // R5: a transfer clears the flag
    p_ovf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_en |=> !st_q.ovf);
    // R5: the flag is only raised by an arriving word
    p_ovf_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovf) |-> $past(shift_en));
endmodule

// File: rtl/serial_nibble_wport.sv
module serial_nibble_wport
    import snw_pkg::*;
#(
    parameter int unsigned W      = WORD_W,
    parameter int unsigned N      = DEPTH,
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_clk_i,
    input  logic [W-1:0]   data_i,
    input  logic           wr_xfer_n_i,
    output logic [N*W-1:0] latch_o,
    output logic           overflow_o
);
    localparam int unsigned CTRL_W = 2;

    logic [CTRL_W-1:0] ctrl_s, ctrl_rise, ctrl_fall;
    logic [W-1:0]      data_s;
    logic              shift_en, xfer_en;
    logic [N*W-1:0]    sr_q, sr_next;

    snw_sync_pipe #(.WIDTH(CTRL_W), .STAGES(STAGES)) u_ctrl_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({wr_xfer_n_i, shift_clk_i}),
        .sync_o  (ctrl_s)
    );

    snw_sync_pipe #(.WIDTH(W), .STAGES(STAGES)) u_data_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (data_i),
        .sync_o  (data_s)
    );

    snw_edge_det #(.WIDTH(CTRL_W)) u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (ctrl_s),
        .rise_o  (ctrl_rise),
        .fall_o  (ctrl_fall)
    );

    assign shift_en = ctrl_rise[0];
    assign xfer_en  = ctrl_fall[1];

    snw_shift_reg #(.W(W), .N(N)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .din       (data_s),
        .sr_o      (sr_q),
        .sr_next_o (sr_next)
    );

    snw_xfer_latch #(.W(W), .N(N)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .xfer_en    (xfer_en),
        .sr_next_i  (sr_next),
        .latch_o    (latch_o),
        .overflow_o (overflow_o)
    );

    // R3: a plain transfer copies the register as it stood
    p_xfer_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && !shift_en) |=> latch_o == $past(sr_q));
    // R7: a coincident word lands as the most recent latch word
    p_coincide_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && shift_en) |=> latch_o[N*W-1 -: W] == $past(data_s));
endmodule

// File: tb/serial_nibble_wport_tb_top.sv
module serial_nibble_wport_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shift_clk = 1'b0;
    logic [3:0]  data = 4'h0;
    logic        wr_xfer_n = 1'b1;
    logic [63:0] latch;
    logic        ovf;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    bit          done     = 1'b0;

    logic [63:0] model = '0;
    int unsigned batch = 0;

    always #5 clk = ~clk;

    serial_nibble_wport dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_clk_i (shift_clk),
        .data_i      (data),
        .wr_xfer_n_i (wr_xfer_n),
        .latch_o     (latch),
        .overflow_o  (ovf)
    );

    // {word count, base value}
    localparam logic [11:0] VEC [6] = '{
        {8'd16, 4'h0}, {8'd16, 4'h5}, {8'd5, 4'hA},
        {8'd17, 4'h3}, {8'd20, 4'hC}, {8'd33, 4'h7}
    };

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic shift_word(input logic [3:0] v);
        data = v;
        wait_cyc(3);
        shift_clk = 1'b1;
        wait_cyc(4);
        shift_clk = 1'b0;
        wait_cyc(4);
        model = {v, model[63:4]};
        batch++;
    endtask

    task automatic xfer();
        wr_xfer_n = 1'b0;
        wait_cyc(5);
        wr_xfer_n = 1'b1;
        wait_cyc(4);
        batch = 0;
    endtask

    initial begin
        #1ms;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        wait_cyc(4);
        // R1: reset state
        check("R1 latch", latch, 64'h0);
        check("R1 ovf", {63'h0, ovf}, 64'h0);
        rst_n = 1'b1;
        wait_cyc(4);
        check("R1 after release", latch, 64'h0);

        // R2 R3 R4 R5: vector table
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < int'(VEC[k][11:4]); i++) begin
                shift_word(VEC[k][3:0] + 4'(i));
            end
            check("R5 ovf before xfer", {63'h0, ovf}, {63'h0, batch > 16});
            xfer();
            check("R3 R4 latch contents", latch, model);
            check("R5 ovf cleared", {63'h0, ovf}, 64'h0);
        end

        // R5: flag stays low at 16, rises on the 17th
        for (int i = 0; i < 16; i++) shift_word(4'(i * 3));
        check("R5 no ovf at 16", {63'h0, ovf}, 64'h0);
        shift_word(4'h9);
        check("R5 ovf at 17", {63'h0, ovf}, 64'h1);

        // R3 R6: falling edge loads, shifting after it leaves latch, rising edge ignored
        wr_xfer_n = 1'b0;
        wait_cyc(5);
        batch = 0;
        check("R3 falling edge load", latch, model);
        held = latch;
        shift_word(4'hE);
        shift_word(4'h1);
        check("R6 latch holds while shifting", latch, held);
        wr_xfer_n = 1'b1;
        wait_cyc(5);
        check("R3 rising edge ignored", latch, held);
        for (int i = 0; i < 14; i++) shift_word(4'(i + 2));
        xfer();
        check("R6 no word lost across transfer", latch, model);

        // R7: coincident shift and transfer edges
        data = 4'hB;
        wait_cyc(3);
        shift_clk = 1'b1;
        wr_xfer_n = 1'b0;
        wait_cyc(5);
        model = {4'hB, model[63:4]};
        batch = 0;
        check("R7 coincident word in latch", latch, model);
        check("R7 word15 value", {60'h0, latch[63:60]}, 64'hB);
        shift_clk = 1'b0;
        wr_xfer_n = 1'b1;
        wait_cyc(4);
        for (int i = 0; i < 16; i++) shift_word(4'(15 - i));
        check("R7 coincident word charged to old batch", {63'h0, ovf}, 64'h0);
        xfer();
        check("R2 one word per rising edge", latch, model);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule